// File: doc/BRIEF.md
# Pairwise-Max Weighted Accumulator

This block consumes a block of ten unsigned samples, one per accepted handshake, and reduces every pair of neighbouring samples (first with second, second with third, and so on up to ninth with tenth) to the larger of the two. The nine maxima are dealt out in turn over three running sums: pairs one, four and seven go to the first sum, pairs two, five and eight to the second, and pairs three, six and nine to the third. Each sum is then weighted by a fixed coefficient: 2 for the first, 1.75 for the second and 2.25 for the third. The three weighted words come out with two fractional bits, so each value is four times the real result.

Only two sample values are ever live, the incoming one and the one before it. The three running sums are the only other data state. The coefficients are made from shifts and one add or subtract each, with no multiplier. A start pulse clears the sums and opens a new block, and it may arrive at any time. A one-cycle done pulse marks the point where all three words are final, and the words then hold until the next start.

Top module: `pmx_accum`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `done_o` is 0 and all three result words are 0.
- R2: Result word m is `res_o[m*RES_W +: RES_W]`, in units of one quarter. Word 0 is 8·S0, word 1 is 7·S1 and word 2 is 9·S2. Here Sm is the sum of the pair maxima whose pair number p (0 to 8, pair p joining sample p and sample p+1 of the block) satisfies p mod 3 = m.
- R3: Each pair contributes the larger of its two samples. When the two are equal, that common value is used.
- R4: `done_o` is high for exactly one cycle, the cycle right after the clock edge that accepts the tenth sample of a block.
- R5: A sample is accepted only on an edge where `smp_valid_i` is 1, `start_i` is 0 and a block is open. Cycles with `smp_valid_i` at 0, and valid samples offered before any start or after a block has finished, leave the count and the results unchanged.
- R6: After `done_o`, the three result words hold their values until the next start pulse.
- R7: A start pulse clears all three result words to 0 from the next cycle, aborts any open block, and opens a new block of ten samples. A sample presented together with start is not taken.
- R8: No result overflows. With every sample at the maximum value 255, the words are exactly 6120, 5355 and 6885.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears the results and opens a new block |
| smp_valid_i | input | 1 | Qualifies `smp_i` |
| smp_i | input | DW (8) | Unsigned sample |
| res_o | output | 3·RES_W (42) | Three weighted words in quarter units, word m at bits m·RES_W upward |
| done_o | output | 1 | One-cycle pulse when a block's results are final |

## Verification
The assertions assume that `start_i` and `smp_valid_i` are 0 or 1, never unknown, once reset is released. They also assume that a sample with its valid bit set is free to be dropped whenever no block is open. The overflow check relies on the sample width in use being the one that sets the accumulator guard bits. The stimulus always drives both control inputs to known levels from time zero. It varies the gaps between samples at random and offers valid data while the block is idle or has just finished. Start pulses come only as whole-cycle pulses, both between blocks and in the middle of one.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int NSAMP = 10;               // samples per block
  localparam int NACC  = 3;                // running sums
  localparam int PAIRS_PER_ACC = (NSAMP - 1) / NACC;
  localparam int FRAC  = 2;                // fractional bits, quarter terms exact
  localparam int COEF_INT_W = 2;           // every coefficient is below 4

  typedef enum logic [1:0] {
    K_TWO      = 2'd0,   // x2
    K_SEVEN_Q  = 2'd1,   // x1.75 = 2 - 1/4
    K_NINE_Q   = 2'd2    // x2.25 = 2 + 1/4
  } coef_e;

  function automatic coef_e kind_of(input int idx);
    case (idx)
      0:       return K_TWO;
      1:       return K_SEVEN_Q;
      default: return K_NINE_Q;
    endcase
  endfunction
endpackage

// File: rtl/pmx_ctrl.sv
module pmx_ctrl
  import pmx_pkg::*;
#(
  parameter int N_SMP = NSAMP,
  parameter int N_ACC = NACC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             valid_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [N_ACC-1:0] acc_en_o,
  output logic             done_o
);
  localparam int CW = $clog2(N_SMP);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [N_ACC-1:0] slot_q, slot_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             pair_ok;

  always_comb begin
    accept_o = busy_q & valid_i & ~start_i;
    pair_ok  = accept_o & (cnt_q != '0);
    acc_en_o = pair_ok ? slot_q : '0;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    if (start_i) begin
      cnt_d  = '0;
      slot_d = N_ACC'(1);
      busy_d = 1'b1;
    end else if (accept_o) begin
      cnt_d = cnt_q + 1'b1;
      if (pair_ok) slot_d = {slot_q[N_ACC-2:0], slot_q[N_ACC-1]};
      if (cnt_q == CW'(N_SMP - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= N_ACC'(1);
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2: at most one sum takes a maximum per cycle
  p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_en_o));
  // R4: done never lasts two cycles
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: done closes the block
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R5: nothing is summed while idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (acc_en_o == '0));
  // R7: start always opens a block
  p_start_opens_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && !done_q));
endmodule

// File: rtl/pmx_pairmax.sv
module pmx_pairmax #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] smp_i,
  output logic [DW-1:0] max_o
);
  logic [DW-1:0] prev_q, prev_d;
  logic [DW:0]   diff;
  logic          cur_wins;

  always_comb begin
    prev_d   = load_i ? smp_i : prev_q;
    diff     = {1'b0, smp_i} - {1'b0, prev_q};
    cur_wins = ~diff[DW] & (diff != '0);   // strictly positive difference
    max_o    = cur_wins ? smp_i : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  // R3: the chosen value is one of the pair and not below either
  p_pair_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> ((max_o >= smp_i) && (max_o >= prev_q) &&
                ((max_o == smp_i) || (max_o == prev_q))));
endmodule

// File: rtl/pmx_scale.sv
module pmx_scale
  import pmx_pkg::*;
#(
  parameter int    SUM_W = 10,
  parameter int    RES_W = 14,
  parameter coef_e KIND  = K_TWO
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [RES_W-1:0] res_o
);
  logic [RES_W-1:0] fx, twice, quarter;

  assign fx      = RES_W'(sum_i) << FRAC;
  assign twice   = fx << 1;
  assign quarter = fx >> 2;

  generate
    if (KIND == K_TWO) begin : g_two
      assign res_o = twice;
    end else if (KIND == K_SEVEN_Q) begin : g_seven
      assign res_o = twice - quarter;
    end else begin : g_nine
      assign res_o = twice + quarter;
    end
  endgenerate
endmodule

// File: rtl/pmx_accum.sv
module pmx_accum
  import pmx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  smp_valid_i,
  input  logic [DW-1:0]         smp_i,
  output logic [3*(DW+$clog2(PAIRS_PER_ACC+1)+COEF_INT_W+FRAC)-1:0] res_o,
  output logic                  done_o
);
  localparam int SUM_W = DW + $clog2(PAIRS_PER_ACC + 1);
  localparam int RES_W = SUM_W + COEF_INT_W + FRAC;

  logic             accept, busy;
  logic [NACC-1:0]  acc_en;
  logic [DW-1:0]    pair_max;
  logic [NACC-1:0][SUM_W-1:0] acc_q, acc_d;

  pmx_ctrl #(.N_SMP(NSAMP), .N_ACC(NACC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .valid_i  (smp_valid_i),
    .accept_o (accept),
    .busy_o   (busy),
    .acc_en_o (acc_en),
    .done_o   (done_o)
  );

  pmx_pairmax #(.DW(DW)) u_pmax (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .smp_i (smp_i),
    .max_o (pair_max)
  );

  genvar g;
  generate
    for (g = 0; g < NACC; g++) begin : g_acc
      always_comb begin
        if (start_i)        acc_d[g] = '0;
        else if (acc_en[g]) acc_d[g] = acc_q[g] + SUM_W'(pair_max);
        else                acc_d[g] = acc_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q[g] <= '0;
        else        acc_q[g] <= acc_d[g];
      end

      pmx_scale #(.SUM_W(SUM_W), .RES_W(RES_W), .KIND(kind_of(g))) u_scale (
        .sum_i(acc_q[g]),
        .res_o(res_o[g*RES_W +: RES_W])
      );

      // R8: adding a maximum never wraps the sum
      p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en[g] && !start_i) |-> (acc_d[g] >= acc_q[g]));
    end
  endgenerate

  // R7: start leaves every sum at zero
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (acc_q == '0));
  // R6: once idle, results hold until a start
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(res_o));
  // R5: an edge without an accepted sample changes no sum
  p_no_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !start_i) |=> $stable(acc_q));
endmodule

// File: tb/sim_pmx_accum.sv
module sim_pmx_accum;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int RES_W = 14;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              rst_n, start, smp_valid, done;
  logic [DW-1:0]     smp;
  logic [3*RES_W-1:0] res;

  pmx_accum #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .smp_valid_i(smp_valid),
    .smp_i(smp), .res_o(res), .done_o(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] blk [10];

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int word_exp(input int m);
    int s = 0;
    for (int p = 0; p < 9; p++)
      if (p % 3 == m) s += (blk[p] > blk[p+1]) ? int'(blk[p]) : int'(blk[p+1]);
    return (m == 0) ? s * 8 : (m == 1) ? s * 7 : s * 9;
  endfunction

  task automatic check_words(input string req);
    for (int m = 0; m < 3; m++) chk(req, int'(res[m*RES_W +: RES_W]), word_exp(m));
  endtask

  task automatic check_zero(input string req);
    for (int m = 0; m < 3; m++) chk(req, int'(res[m*RES_W +: RES_W]), 0);
  endtask

  // called at a negedge, returns at a negedge
  task automatic send(input logic [DW-1:0] v, input int gap);
    smp_valid = 1'b1; smp = v;
    @(negedge clk);
    smp_valid = 1'b0;
    for (int k = 0; k < gap; k++) begin
      smp = DW'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_zero("R7 cleared by start");
  endtask

  task automatic run_block(input int gapmax);
    for (int i = 0; i < 10; i++) begin
      if (i > 0) chk("R4 no early done", int'(done), 0);
      send(blk[i], (i == 9) ? 0 : int'($urandom_range(gapmax, 0)));
    end
    chk("R4 done after tenth", int'(done), 1);
    check_words("R2 R3 weighted words");
    // idle with valid data offered: must be ignored
    smp_valid = 1'b1; smp = DW'($urandom);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
    for (int k = 0; k < 2; k++) begin
      smp = DW'($urandom);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    chk("R5 no done while idle", int'(done), 0);
    check_words("R6 R5 words held");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; smp_valid = 1'b0; smp = '0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    check_zero("R1 words in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    check_zero("R1 words after reset");

    // R5: valid data before any start is ignored
    smp_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin smp = 8'hFF; @(negedge clk); end
    smp_valid = 1'b0;
    chk("R5 no done before start", int'(done), 0);
    check_zero("R5 ignored before start");

    // directed: all zero
    foreach (blk[i]) blk[i] = '0;
    pulse_start(); run_block(0);
    // R8: all maximum, exact 6120 / 5355 / 6885
    foreach (blk[i]) blk[i] = 8'hFF;
    pulse_start(); run_block(2);
    chk("R8 word0 full scale", int'(res[0 +: RES_W]), 6120);
    chk("R8 word1 full scale", int'(res[RES_W +: RES_W]), 5355);
    chk("R8 word2 full scale", int'(res[2*RES_W +: RES_W]), 6885);
    // R3: rising, falling, equal
    foreach (blk[i]) blk[i] = DW'(i * 20 + 1);
    pulse_start(); run_block(1);
    foreach (blk[i]) blk[i] = DW'(250 - i * 23);
    pulse_start(); run_block(1);
    foreach (blk[i]) blk[i] = 8'd7;
    pulse_start(); run_block(0);
    foreach (blk[i]) blk[i] = (i % 2 == 0) ? 8'd200 : 8'd13;
    pulse_start(); run_block(3);

    // R7: abort mid block, then a full block
    pulse_start();
    for (int i = 0; i < 4; i++) send(8'hF0, 1);
    pulse_start();
    foreach (blk[i]) blk[i] = DW'($urandom);
    run_block(2);

    // R7: sample presented together with start is not taken
    start = 1'b1; smp_valid = 1'b1; smp = 8'hFF;
    @(negedge clk);
    start = 1'b0; smp_valid = 1'b0;
    check_zero("R7 start with valid");
    foreach (blk[i]) blk[i] = DW'($urandom_range(100, 0));
    run_block(1);

    // constrained random blocks
    for (int b = 0; b < 150; b++) begin
      foreach (blk[i]) blk[i] = DW'($urandom);
      if (b % 5 == 0) blk[3] = blk[4];
      pulse_start();
      run_block(3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule